// File: doc/BRIEF.md
# I2C Register-Port Target

This block is an I2C bus target that lets a host reach a bank of 64 byte-wide registers. The registers sit outside the block, on a simple register bus. The target watches SCL and SDA, finds START and STOP conditions, and answers only frames that carry its fixed 7-bit device address. In a write frame, the byte after the address loads a 6-bit register pointer. Every following data byte is written to that same register.

A read frame returns the register that the pointer selects, once for every byte the host clocks out. The pointer never advances. This lets a host stream bytes into or out of a FIFO-style register, or poll a status register in one frame. The pointer is kept after STOP, so a host may read again without first sending a pointer-setting write.

Each byte written gives one write strobe and each byte read gives one read strobe. A FIFO register behind the bus therefore pushes or pops exactly one entry per byte. SDA is open-drain: the block only reports when it pulls the line low.

Top module: `i2c_regport_slave`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` is 0, `reg_addr` is 0 and neither `reg_we` nor `reg_re` pulses.
- R2: A frame whose first byte has its upper 7 bits equal to `DEV_ADDR` (default 7'h2A) is acknowledged: SDA is held low for the whole ninth SCL high period.
- R3: A frame with any other address byte is not acknowledged. Its later bytes get no acknowledge and cause no strobe, and `reg_addr` does not change.
- R4: In a write frame (address byte bit 0 = 0), the second byte is acknowledged and its low 6 bits become `reg_addr`. Bits 7:6 are ignored.
- R5: Each further byte of a write frame is acknowledged. Each gives exactly one single-cycle `reg_we` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. `reg_we` and `reg_re` are never high together.
- R6: In a read frame (address byte bit 0 = 1), each byte gives one single-cycle `reg_re` pulse. `reg_rdata` is taken the clock after that pulse and sent MSB first.
- R7: The pointer never increments: all strobes of one frame use the same `reg_addr`, and `reg_addr` does not change while a strobe is high.
- R8: The pointer is kept across STOP, so a read frame with no write frame before it returns the last selected register.
- R9: After the host answers a read byte with NACK (SDA high in the ninth bit), the block releases SDA and issues no further `reg_re` until the next START.
- R10: A repeated START is handled like a START. The address byte is checked again, and the pointer keeps its value.
- R11: `sda_oe` changes only while SCL is low.
- R12: A write frame that holds only the address and pointer bytes produces no `reg_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_addr | output | AW | Register pointer |
| reg_wdata | output | DW | Write data |
| reg_we | output | 1 | Write strobe, one cycle per byte |
| reg_re | output | 1 | Read strobe, one cycle per byte |
| reg_rdata | input | DW | Read data, valid the clock after `reg_re` |

## Verification
SCL and SDA pass through SYNC_STAGES flops and then one edge-detect flop before the state machine sees them. Each result is therefore registered about three to four system clocks after the bus edge that causes it. This applies to a write or read strobe after the eighth rising SCL, and to an SDA drive change after a falling SCL. The bench master holds each SCL phase for at least eight clocks. It samples SDA four clocks into the SCL high phase, which is after every drive change has settled. Strobes are compared against the reference queue on every falling clock edge, and strobe counts are checked only after each frame has fully ended.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVADR, ST_ACK, ST_PTR, ST_WDATA, ST_RDATA, ST_RACK, ST_SKIP
  } st_e;

  // Phase entered after an acknowledge slot completes
  typedef enum logic [1:0] {NX_PTR, NX_WDATA, NX_RDATA} nxt_e;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '1;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // SDA edges while SCL stays high mark frame boundaries
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter int            AW       = 6,
  parameter int            DW       = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          sda_s,
  input  logic [DW-1:0] reg_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  st_e           st;
  nxt_e          nxt;
  logic [DW-1:0] rx, tx;
  logic [CW-1:0] cnt;
  logic          ph, re_d;
  logic [DW-1:0] rx_byte;

  assign rx_byte = {rx[DW-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      nxt       <= NX_PTR;
      rx        <= '0;
      tx        <= '0;
      cnt       <= '0;
      ph        <= 1'b0;
      re_d      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      re_d   <= reg_re;
      if (re_d) tx <= reg_rdata;

      if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= ST_DEVADR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_DEVADR: if (scl_rise) begin
            rx  <= rx_byte;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
              if (rx_byte[DW-1:1] == DEV_ADDR) begin
                st <= ST_ACK;
                ph <= 1'b0;
                if (rx_byte[0]) begin
                  nxt    <= NX_RDATA;
                  reg_re <= 1'b1;
                end else begin
                  nxt <= NX_PTR;
                end
              end else begin
                st <= ST_SKIP;
              end
            end
          end

          ST_ACK: if (scl_fall) begin
            if (!ph) begin
              ph     <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ph  <= 1'b0;
              cnt <= '0;
              unique case (nxt)
                NX_PTR:   begin st <= ST_PTR;   sda_oe <= 1'b0; end
                NX_WDATA: begin st <= ST_WDATA; sda_oe <= 1'b0; end
                default:  begin st <= ST_RDATA; sda_oe <= ~tx[DW-1]; end
              endcase
            end
          end

          ST_PTR: if (scl_rise) begin
            rx  <= rx_byte;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
              reg_addr <= rx_byte[AW-1:0];
              st       <= ST_ACK;
              nxt      <= NX_WDATA;
              ph       <= 1'b0;
            end
          end

          ST_WDATA: if (scl_rise) begin
            rx  <= rx_byte;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
              reg_wdata <= rx_byte;
              reg_we    <= 1'b1;
              st        <= ST_ACK;
              nxt       <= NX_WDATA;
              ph        <= 1'b0;
            end
          end

          ST_RDATA: if (scl_fall) begin
            if (cnt == LAST) begin
              st     <= ST_RACK;
              sda_oe <= 1'b0;
              cnt    <= '0;
              ph     <= 1'b0;
            end else begin
              sda_oe <= ~tx[DW-2];
              tx     <= {tx[DW-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end

          ST_RACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                reg_re <= 1'b1;
                ph     <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end else if (scl_fall && ph) begin
              ph     <= 1'b0;
              st     <= ST_RDATA;
              sda_oe <= ~tx[DW-1];
            end
          end

          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
  parameter int            AW          = 6,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-2:0] DEV_ADDR    = 7'h2A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  logic [1:0] bus_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_rp_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );

  i2c_rp_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  i2c_rp_engine #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(bus_s[0]),
    .reg_rdata(reg_rdata), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re)
  );
endmodule

// File: rtl/i2c_rp_chk.sv
module i2c_rp_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          reg_we,
  input logic          reg_re,
  input logic [AW-1:0] reg_addr
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  p_we_scl_high_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> scl_i);

  p_re_single_r6: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);

  p_ptr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_addr) |-> (!reg_we && !reg_re));

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_regport_slave i2c_rp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_regport_slave.sv
module sim_i2c_regport_slave;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam logic [5:0] FIFO = 6'h3F;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regport_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_fail = 0, we_seen = 0, re_seen = 0, oe_viol = 0;
  logic [13:0] exp_we[$];
  logic [5:0]  exp_raddr;
  logic [7:0]  mem[64];
  logic [7:0]  fifo_q[$];
  logic        prev_oe = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Register bank model: data one clock after the read strobe
  initial for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5A;
  initial reg_rdata = '0;
  always @(posedge clk) begin
    if (reg_we) begin
      if (reg_addr == FIFO) fifo_q.push_back(reg_wdata);
      else mem[reg_addr] <= reg_wdata;
    end
    if (reg_re) begin
      if (reg_addr == FIFO) reg_rdata <= (fifo_q.size() > 0) ? fifo_q.pop_front() : 8'hEE;
      else reg_rdata <= mem[reg_addr];
    end
  end

  // Every-clock comparison against the expected strobe stream
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        we_seen++;
        if (exp_we.size() == 0) check(0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [13:0] e;
          e = exp_we.pop_front();
          check({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_re) begin
        re_seen++;
        check(reg_addr == exp_raddr, "R7 read address", reg_addr, exp_raddr);
      end
      if (sda_oe != prev_oe && scl_m) oe_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; tick(4); scl_m = 1; tick(8); sda_m = 0; tick(8); scl_m = 0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(4); scl_m = 1; tick(8); sda_m = 1; tick(8);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(4); scl_m = 1; tick(8); scl_m = 0; tick(4);
    end
    sda_m = 1; tick(4); scl_m = 1; tick(4); ackd = !sda_line; tick(4); scl_m = 0; tick(4);
  endtask

  task automatic rd_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(4); scl_m = 1; tick(4); b[i] = sda_line; tick(4); scl_m = 0; tick(4);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(4); scl_m = 1; tick(8); scl_m = 0; tick(4);
    sda_m = 1;
  endtask

  task automatic clear_counts(); we_seen = 0; re_seen = 0; endtask

  initial begin
    bit a;
    logic [7:0] d;
    // R1: reset state
    tick(5);
    check(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 outputs in reset", {sda_oe, reg_we, reg_re}, 0);
    rst = 0; tick(10);
    check(sda_oe == 0 && reg_addr == 0, "R1 outputs after reset", {sda_oe, reg_addr}, 0);

    // R3: foreign address, no ack, no strobes, pointer untouched
    clear_counts();
    bus_start(); wr_byte({7'h11, 1'b0}, a);
    check(!a, "R3 foreign address acked", a, 0);
    wr_byte(8'h05, a); check(!a, "R3 later byte acked", a, 0);
    wr_byte(8'h99, a); bus_stop(); tick(20);
    check(we_seen == 0 && re_seen == 0, "R3 strobes", we_seen + re_seen, 0);
    check(reg_addr == 0, "R3 pointer", reg_addr, 0);

    // R2 R4 R5 R7: pointer with high bits set, three data bytes
    clear_counts();
    exp_we.push_back({6'h05, 8'h11}); exp_we.push_back({6'h05, 8'h22}); exp_we.push_back({6'h05, 8'h33});
    bus_start(); wr_byte({DEV, 1'b0}, a); check(a, "R2 address ack", a, 1);
    wr_byte(8'hC5, a); check(a, "R4 pointer ack", a, 1);
    wr_byte(8'h11, a); check(a, "R5 data ack", a, 1);
    wr_byte(8'h22, a); wr_byte(8'h33, a); check(a, "R5 last data ack", a, 1);
    bus_stop(); tick(20);
    check(we_seen == 3, "R7 write strobe count", we_seen, 3);
    check(reg_addr == 6'h05, "R4 pointer low bits", reg_addr, 5);

    // Fill the FIFO register with three bytes
    clear_counts();
    exp_we.push_back({FIFO, 8'hA1}); exp_we.push_back({FIFO, 8'hB2}); exp_we.push_back({FIFO, 8'hC3});
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte({2'b00, FIFO}, a);
    wr_byte(8'hA1, a); wr_byte(8'hB2, a); wr_byte(8'hC3, a); bus_stop(); tick(20);
    check(we_seen == 3, "R5 fifo writes", we_seen, 3);

    // R12: address-only write frame
    clear_counts();
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h7F, a); bus_stop(); tick(20);
    check(we_seen == 0, "R12 no write strobe", we_seen, 0);
    check(reg_addr == FIFO, "R4 pointer from address-only frame", reg_addr, FIFO);

    // R6 R7 R9: stream three pops from the FIFO register
    clear_counts(); exp_raddr = FIFO;
    bus_start(); wr_byte({DEV, 1'b1}, a); check(a, "R2 read address ack", a, 1);
    rd_byte(d, 1); check(d == 8'hA1, "R6 read byte 0", d, 8'hA1);
    rd_byte(d, 1); check(d == 8'hB2, "R6 read byte 1", d, 8'hB2);
    rd_byte(d, 0); check(d == 8'hC3, "R6 read byte 2", d, 8'hC3);
    tick(6); check(sda_oe == 0, "R9 SDA released after NACK", sda_oe, 0);
    tick(40); bus_stop(); tick(20);
    check(re_seen == 3, "R9 read strobe count", re_seen, 3);

    // R8: pointer set, then two read frames with no pointer write between
    clear_counts(); exp_raddr = 6'h05;
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h05, a); bus_stop();
    bus_start(); wr_byte({DEV, 1'b1}, a); rd_byte(d, 0); bus_stop();
    check(d == 8'h33, "R8 read after pointer write", d, 8'h33);
    bus_start(); wr_byte({DEV, 1'b1}, a); rd_byte(d, 0); bus_stop(); tick(20);
    check(d == 8'h33, "R8 read with retained pointer", d, 8'h33);
    check(re_seen == 2 && we_seen == 0, "R8 strobe counts", re_seen * 16 + we_seen, 32);

    // R10: repeated START into a read, then into a foreign address
    clear_counts(); exp_raddr = 6'h12;
    exp_we.push_back({6'h12, 8'h77});
    bus_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h12, a); wr_byte(8'h77, a);
    bus_start(); wr_byte({DEV, 1'b1}, a); check(a, "R10 ack after repeated start", a, 1);
    rd_byte(d, 0); check(d == 8'h77, "R10 read data", d, 8'h77);
    bus_start(); wr_byte({7'h11, 1'b1}, a); check(!a, "R10 foreign address after repeated start", a, 0);
    bus_stop(); tick(20);
    check(reg_addr == 6'h12, "R10 pointer kept", reg_addr, 6'h12);
    check(we_seen == 1 && re_seen == 1, "R10 strobe counts", we_seen * 16 + re_seen, 17);

    check(exp_we.size() == 0, "R5 pending writes", exp_we.size(), 0);
    check(oe_viol == 0, "R11 SDA drive change with SCL high", oe_viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule